// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four pulse-width modulated pins. Each pin has its own pair of cascaded counters. A prescaler divides the input clock into ticks, and a period divider counts those ticks to set the length of one output period. A high-duration count sets how many ticks at the start of each period the pin stays high. Software reaches each channel through one 32-bit control word on a simple strobe-based register bus.

Software writes the timing values into shadow fields, and the running counters never see them directly. The values move into the active set only when software writes a self-clearing commit bit. A channel that is stopped commits at once. A channel that is running waits for the end of its current period, so the waveform never gets a torn period. A run bit starts and stops each channel. The usual sequence is to stop the channel, write the new values, and then write run and commit together in one access.

Top module: `pwm4_prescaled`

## Requirements
- R1: After reset every control word reads 0, every channel is stopped, and every pwm_out bit is low.
- R2: Channel n's control word sits at byte address 0x20+4n. Its fields are: bit 31 run, bit 30 commit pending, bits [29:22] prescaler P, bits [20:10] high count H, bits [9:0] divider D. Bit 21 reads 0. A read returns the shadow fields and appears on bus_rdata in the cycle after bus_rd. A read of any other address returns 0. A write to any other address, including a misaligned one, changes nothing.
- R3: A running channel repeats with a period of (P+1)*(D+1) clock cycles, using its active values.
- R4: In each period the output is high for the first H*(P+1) cycles and low for the rest.
- R5: With H=0 the output stays low. With H >= D+1 the output stays high.
- R6: While run is 0 the output is low and both counters stay at zero, so a later start begins a fresh period.
- R7: A write with run and commit both set to a stopped channel makes the written values active at once, and the commit bit then reads 0.
- R8: A write with commit set to a running channel keeps the old values until the end of the current period. Until then the commit bit reads 1.
- R9: A pending commit on a channel that has been stopped completes on the next clock.
- R10: A write without commit changes the shadow fields and the run bit, but does not change the active timing values.
- R11: The channels run independently of each other, and a write selects at most one channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held between reads |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench goes after several commit corner cases.
- A commit written while a channel runs, placed just after a period boundary. A design that commits at once would shorten that period, and the period and high-time measurements would catch it. A design that never clears the bit would leave commit reading 1.
- A start from stopped with run and commit together. A design that deferred this commit would run one period on stale values.
- A stop written with commit set. If the pending commit were lost, the later restart would show the old timing.
- The constant-low and constant-high extremes of the high count. A design with an off-by-one compare would emit a one-tick glitch in each period.
- Misaligned and out-of-range accesses. A design with loose address decoding would corrupt channel 0 or return data for such addresses.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int PSC_W   = 8;
    localparam int HI_W    = 11;
    localparam int DIV_W   = 10;
    localparam int WORD_W  = 32;

    localparam int RUN_BIT = 31;
    localparam int UPD_BIT = 30;
    localparam int PSC_LSB = 22;
    localparam int HI_LSB  = 10;
    localparam int DIV_LSB = 0;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [HI_W-1:0]  hi;
        logic [DIV_W-1:0] div;
    } pwm_cfg_t;

    typedef struct packed {
        logic             run;
        logic             pend;
        pwm_cfg_t         sh;
        pwm_cfg_t         ac;
        logic [PSC_W-1:0] pcnt;
        logic [DIV_W-1:0] dcnt;
    } chan_state_t;

    function automatic pwm_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        pwm_cfg_t c;
        c.psc = w[PSC_LSB +: PSC_W];
        c.hi  = w[HI_LSB  +: HI_W];
        c.div = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input logic run,
                                                      input logic pend,
                                                      input pwm_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RUN_BIT]             = run;
        w[UPD_BIT]             = pend;
        w[PSC_LSB +: PSC_W]    = c.psc;
        w[HI_LSB  +: HI_W]     = c.hi;
        w[DIV_LSB +: DIV_W]    = c.div;
        return w;
    endfunction

endpackage

// File: rtl/pwm4_bus.sv
module pwm4_bus #(
    parameter int N_CH      = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  logic                      rd_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [N_CH-1:0][31:0]     words_i,
    output logic [N_CH-1:0]           wr_sel_o,
    output logic [31:0]               rdata_o
);
    localparam int SPAN = 4 * N_CH;

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic [N_CH-1:0]   sel;
    logic [31:0]       rdata_d, rdata_q;

    always_comb begin
        off    = addr_i - ADDR_W'(BASE_ADDR);
        in_win = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(SPAN)) &&
                 (off[1:0] == 2'b00);
        for (int i = 0; i < N_CH; i++) begin
            sel[i] = in_win && (off[ADDR_W-1:2] == (ADDR_W-2)'(i));
        end
    end

    assign wr_sel_o = wr_i ? sel : '0;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_i) begin
            rdata_d = '0;
            for (int i = 0; i < N_CH; i++) begin
                if (sel[i]) rdata_d = words_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              run_o,
    output logic              pend_o,
    output logic [WORD_W-1:0] word_o,
    output logic              pwm_o
);
    chan_state_t s_d, s_q;
    logic        tick, wrap;
    pwm_cfg_t    wcfg;

    always_comb begin
        s_d  = s_q;
        wcfg = word_to_cfg(wdata_i);
        tick = s_q.run && (s_q.pcnt == s_q.ac.psc);
        wrap = tick && (s_q.dcnt == s_q.ac.div);

        // cascaded counters, held at zero while stopped
        if (s_q.run) begin
            s_d.pcnt = tick ? '0 : s_q.pcnt + PSC_W'(1);
            if (tick) s_d.dcnt = wrap ? '0 : s_q.dcnt + DIV_W'(1);
        end else begin
            s_d.pcnt = '0;
            s_d.dcnt = '0;
        end

        // deferred commit: at period end, or at once when stopped
        if (s_q.pend && (!s_q.run || wrap)) begin
            s_d.ac   = s_q.sh;
            s_d.pend = 1'b0;
        end

        // software access
        if (wr_i) begin
            s_d.sh  = wcfg;
            s_d.run = wdata_i[RUN_BIT];
            if (wdata_i[UPD_BIT]) begin
                if (!s_q.run) begin
                    s_d.ac   = wcfg;
                    s_d.pend = 1'b0;
                end else begin
                    s_d.pend = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o  = s_q.run;
    assign pend_o = s_q.pend;
    assign word_o = cfg_to_word(s_q.run, s_q.pend, s_q.sh);
    assign pwm_o  = s_q.run && (HI_W'(s_q.dcnt) < s_q.ac.hi);

endmodule

// File: rtl/pwm4_prescaled.sv
module pwm4_prescaled #(
    parameter int N_CH      = 4,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_CH-1:0]   pwm_out
);
    logic [N_CH-1:0][31:0] ch_word;
    logic [N_CH-1:0]       wr_sel;
    logic [N_CH-1:0]       ch_run;
    logic [N_CH-1:0]       ch_pend;

    pwm4_bus #(
        .N_CH      (N_CH),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .words_i  (ch_word),
        .wr_sel_o (wr_sel),
        .rdata_o  (bus_rdata)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm4_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_sel[g]),
            .wdata_i (bus_wdata),
            .run_o   (ch_run[g]),
            .pend_o  (ch_pend[g]),
            .word_o  (ch_word[g]),
            .pwm_o   (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm4_checker.sv
module pwm4_checker #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic [N_CH-1:0] pwm_out,
    input logic [N_CH-1:0] ch_run,
    input logic [N_CH-1:0] ch_pend,
    input logic [N_CH-1:0] wr_sel
);
    p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[21] == 1'b0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[i] |-> !pwm_out[i]);

        p_run_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_sel[i] |=> (ch_run[i] == $past(bus_wdata[31])));

        p_idle_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_pend[i] && !ch_run[i] && !wr_sel[i]) |=> !ch_pend[i]);

        p_start_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_sel[i] && !ch_run[i] && bus_wdata[30]) |=> !ch_pend[i]);
    end

endmodule

bind pwm4_prescaled pwm4_checker #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .ch_run    (ch_run),
    .ch_pend   (ch_pend),
    .wr_sel    (wr_sel)
);

// File: tb/pwm4_prescaled_tb.sv
module pwm4_prescaled_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm4_prescaled u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    // behavioural reference: one position counter per channel
    int m_run[4], m_pend[4], m_pos[4];
    int s_p[4], s_h[4], s_d[4], a_p[4], a_h[4], a_d[4];
    int m_rd;

    function automatic int word_of(int c);
        return (m_run[c] << 31) | (m_pend[c] << 30) | (s_p[c] << 22) |
               (s_h[c] << 10) | s_d[c];
    endfunction

    function automatic int exp_out(int c);
        return (m_run[c] != 0 && m_pos[c] < a_h[c] * (a_p[c] + 1)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_run[c] = 0; m_pend[c] = 0; m_pos[c] = 0;
                s_p[c] = 0; s_h[c] = 0; s_d[c] = 0;
                a_p[c] = 0; a_h[c] = 0; a_d[c] = 0;
            end
            m_rd = 0;
        end else begin
            int a, hitc;
            a = int'(bus_addr);
            hitc = (a[1:0] == 0 && a >= 32 && a < 48) ? (a - 32) / 4 : -1;
            if (bus_rd) m_rd = (hitc >= 0) ? word_of(hitc) : 0;
            for (int c = 0; c < 4; c++) begin
                int last, old_run;
                bit bound;
                old_run = m_run[c];
                last  = (a_p[c] + 1) * (a_d[c] + 1) - 1;
                bound = (m_run[c] != 0) && (m_pos[c] == last);
                m_pos[c] = (m_run[c] != 0) ? (bound ? 0 : m_pos[c] + 1) : 0;
                if (m_pend[c] != 0 && (m_run[c] == 0 || bound)) begin
                    a_p[c] = s_p[c]; a_h[c] = s_h[c]; a_d[c] = s_d[c];
                    m_pend[c] = 0;
                end
                if (bus_wr && hitc == c) begin
                    s_p[c] = (bus_wdata >> 22) & 255;
                    s_h[c] = (bus_wdata >> 10) & 2047;
                    s_d[c] = bus_wdata & 1023;
                    m_run[c] = bus_wdata[31];
                    if (bus_wdata[30]) begin
                        if (old_run == 0) begin
                            a_p[c] = s_p[c]; a_h[c] = s_h[c]; a_d[c] = s_d[c];
                            m_pend[c] = 0;
                        end else m_pend[c] = 1;
                    end
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 4; c++)
                chk(int'(pwm_out[c]) == exp_out(c), "R11 model pwm_out",
                    int'(pwm_out[c]), exp_out(c));
            chk(bus_rdata == m_rd, "R2 model rdata", bus_rdata, m_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_rise(int c);
        while (pwm_out[c]) @(negedge clk);
        while (!pwm_out[c]) @(negedge clk);
    endtask

    task automatic measure(int c, output int hi, output int per);
        int lo;
        wait_rise(c);
        hi = 0; lo = 0;
        while (pwm_out[c]) begin hi++; @(negedge clk); end
        while (!pwm_out[c]) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask

    initial begin
        logic [31:0] d;
        int hi, per, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pwm_out == 4'b0, "R1 outputs low", pwm_out, 0);
        for (int c = 0; c < 4; c++) begin
            rd(8'h20 + 8'(4 * c), d);
            chk(d == 32'h0, "R1 word zero", d, 0);
        end
        // R2: field layout and decode
        wr(8'h24, 32'h0140_2414);
        rd(8'h24, d);
        chk(d == 32'h0140_2414, "R2 readback", d, 32'h0140_2414);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, d);
        chk(d == 32'h0, "R2 unmapped read", d, 0);
        wr(8'h21, 32'hC080_0804);
        rd(8'h20, d);
        chk(d == 32'h0, "R2 misaligned write ignored", d, 0);
        chk(pwm_out[0] == 1'b0, "R2 misaligned no start", pwm_out[0], 0);
        // R7: start with run+commit
        wr(8'h20, 32'hC080_0804);
        rd(8'h20, d);
        chk(d == 32'h8080_0804, "R7 commit cleared on start", d, 32'h8080_0804);
        // R3 / R4: P=2 D=4 H=2
        measure(0, hi, per);
        chk(per == 15, "R3 period", per, 15);
        chk(hi == 6, "R4 high time", hi, 6);
        // R5: H=0 and H>=D+1
        wr(8'h28, 32'hC000_0003);
        wr(8'h2C, 32'hC040_1003);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (pwm_out[2] == 1'b0 && pwm_out[3] == 1'b1) cnt++;
            @(negedge clk);
        end
        chk(cnt == 40, "R5 constant levels", cnt, 40);
        // R10: write without commit leaves timing
        wr(8'h20, 32'h81C0_0409);
        measure(0, hi, per);
        chk(per == 15 && hi == 6, "R10 timing unchanged", per, 15);
        rd(8'h20, d);
        chk(d == 32'h81C0_0409, "R10 shadow updated", d, 32'h81C0_0409);
        // R8: commit while running, just after a period start
        wait_rise(0);
        wr(8'h20, 32'hC1C0_0409);
        rd(8'h20, d);
        chk(d == 32'hC1C0_0409, "R8 commit pending", d, 32'hC1C0_0409);
        chk(pwm_out[0] == 1'b1, "R8 old high time continues", pwm_out[0], 1);
        measure(0, hi, per);
        chk(per == 80, "R8 new period", per, 80);
        chk(hi == 8, "R8 new high time", hi, 8);
        rd(8'h20, d);
        chk(d == 32'h81C0_0409, "R8 commit done", d, 32'h81C0_0409);
        // R9 / R6: stop with commit pending
        wr(8'h20, 32'h4040_0401);
        chk(pwm_out[0] == 1'b0, "R6 low when stopped", pwm_out[0], 0);
        @(negedge clk);
        rd(8'h20, d);
        chk(d == 32'h0040_0401, "R9 idle commit done", d, 32'h0040_0401);
        wr(8'h20, 32'h8040_0401);
        measure(0, hi, per);
        chk(per == 4 && hi == 2, "R6 restart uses committed values", per, 4);
        // R11: untouched channel idle throughout
        chk(pwm_out[1] == 1'b0, "R11 channel 1 idle", pwm_out[1], 0);
        repeat (20) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule